// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers 32 interrupt inputs into one bank and drives two active-low request lines: a normal interrupt line and a fast interrupt line. Each input has its own configuration word. The word sets the input's priority, chooses level or rising-edge sensing, and says whether the input goes to the fast line. Inputs become eligible when they are pending, not masked, and the bank-wide gate is open. For each line, the block picks the eligible input with the best priority.

The winning input's number is latched into that line's source register. It stays frozen until software writes an acknowledge into the control word. The acknowledge releases the line, so a fresh arbitration can take place on the next cycle.

A parameter removes fast-interrupt routing, so that a copy of the block can act as a second-level bank. A second parameter adds a fixed offset to the reported numbers; a value of 32 suits a bank that feeds the first bank through one of its inputs. In that arrangement, software acknowledges both banks.

Top module: `prio_irq_bank`

## Requirements
- R1: After reset, every mask bit reads 1, the global gate reads 1, every configuration word reads 0, and both irq_n and fiq_n are high.
- R2: The configuration word of input i is at word address i (0 to 31). Bit 0 routes the input to the fast line. Bit 1 selects sensing: 1 means level, 0 means rising edge. Bits 6:2 hold the priority. Bits above 6 read as 0.
- R3: When FIQ_EN is 0, bit 0 of every configuration word reads 0, and fiq_n never goes low. Inputs whose bit 0 is set (with FIQ_EN 1) request only the fast line.
- R4: The mask word is at address 33. A 1 in bit i keeps input i from requesting, even while it is pending.
- R5: The pending word is at address 32. A level input's bit follows the input. An edge input's bit is set by a rising transition and stays set. Writing the pending word clears every edge bit whose written bit is 0.
- R6: The global gate is at address 37, bit 0. While it is 1, no request is raised. Writing 0 opens delivery for the whole bank.
- R7: The lowest priority value wins. Between equal priorities, the lower input index wins.
- R8: The normal and fast source words are at addresses 34 and 35. While the line is low, each reads NUM_BASE plus the latched index; otherwise it reads 0. The latched index does not change until acknowledged, even when a better input becomes pending.
- R9: The control word is at address 36. Writing bit 0 as 1 acknowledges the normal line, and writing bit 1 as 1 acknowledges the fast line. The acknowledged line is high in the cycle after the write and may go low again one cycle later.
- R10: Acknowledging a line clears the pending bit of its latched input when that input is edge-sensed.
- R11: With NUM_BASE set to 32, a request from local input i reports 32 + i in the source word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational from addr) |
| src_in | input | 32 | Interrupt inputs, active high |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |

## Verification
The embedded assertions check, on every cycle, that:
- an acknowledge write returns its line high on the next cycle;
- a latched index never changes while its line is held;
- a closed global gate keeps an idle line idle;
- a line is seized only when an eligible candidate existed.

The choice of winner cannot be shown by those cycle-level properties, so the bench scenarios demonstrate it. The scenarios also cover:
- priority order and tie-breaking;
- sticky edge capture and its clearing by acknowledge or a pending-word write;
- masking;
- the fast-line split;
- the offset numbering of a second-level copy.

// File: rtl/prio_irq_bank.sv
module prio_irq_bank #(
  parameter int NSRC     = 32,
  parameter int PRIO_W   = 5,
  parameter int FIQ_EN   = 1,
  parameter int NUM_BASE = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] src_in,
  output logic        irq_n,
  output logic        fiq_n
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int CFG_W = PRIO_W + 2;
  localparam logic [5:0] A_PEND = 6'd32;
  localparam logic [5:0] A_MASK = 6'd33;
  localparam logic [5:0] A_ISRC = 6'd34;
  localparam logic [5:0] A_FSRC = 6'd35;
  localparam logic [5:0] A_CTRL = 6'd36;
  localparam logic [5:0] A_GATE = 6'd37;

  logic [CFG_W-1:0] cfg [NSRC];
  logic [NSRC-1:0] mask_r, edge_pend, ep_nxt, src_q, pend, elig, trig, fiq_rt;
  logic gate;
  logic irq_act, fiq_act, irq_hit, fiq_hit;
  logic [IDX_W-1:0] irq_idx, fiq_idx, irq_sel, fiq_sel;
  logic [PRIO_W-1:0] irq_best, fiq_best;

  wire ack_irq = wr_en && addr == A_CTRL && wdata[0];
  wire ack_fiq = wr_en && addr == A_CTRL && wdata[1];

  always_comb
    for (int i = 0; i < NSRC; i++) begin
      trig[i]   = cfg[i][1];
      fiq_rt[i] = cfg[i][0];
    end

  assign pend = (trig & src_in) | (~trig & edge_pend);
  assign elig = gate ? '0 : (pend & ~mask_r);

  always_comb begin
    irq_hit = 1'b0; irq_sel = '0; irq_best = '1;
    fiq_hit = 1'b0; fiq_sel = '0; fiq_best = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && !fiq_rt[i] && (!irq_hit || cfg[i][CFG_W-1:2] < irq_best)) begin
        irq_hit = 1'b1; irq_sel = i[IDX_W-1:0]; irq_best = cfg[i][CFG_W-1:2];
      end
      if (elig[i] && fiq_rt[i] && (!fiq_hit || cfg[i][CFG_W-1:2] < fiq_best)) begin
        fiq_hit = 1'b1; fiq_sel = i[IDX_W-1:0]; fiq_best = cfg[i][CFG_W-1:2];
      end
    end
  end

  always_comb begin
    ep_nxt = edge_pend;
    if (wr_en && addr == A_PEND) ep_nxt = ep_nxt & wdata[NSRC-1:0];
    if (ack_irq && irq_act) ep_nxt[irq_idx] = 1'b0;
    if (ack_fiq && fiq_act) ep_nxt[fiq_idx] = 1'b0;
    ep_nxt = ep_nxt | (src_in & ~src_q & ~trig);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) cfg[i] <= '0;
      mask_r <= '1; gate <= 1'b1; edge_pend <= '0; src_q <= '0;
      irq_act <= 1'b0; fiq_act <= 1'b0; irq_idx <= '0; fiq_idx <= '0;
    end else begin
      src_q <= src_in;
      edge_pend <= ep_nxt;
      if (wr_en && addr < 6'(NSRC))
        cfg[addr[IDX_W-1:0]] <= {wdata[CFG_W-1:1], wdata[0] & (FIQ_EN != 0)};
      if (wr_en && addr == A_MASK) mask_r <= wdata[NSRC-1:0];
      if (wr_en && addr == A_GATE) gate <= wdata[0];
      if (ack_irq) irq_act <= 1'b0;
      else if (!irq_act && irq_hit) begin irq_act <= 1'b1; irq_idx <= irq_sel; end
      if (ack_fiq) fiq_act <= 1'b0;
      else if (!fiq_act && fiq_hit) begin fiq_act <= 1'b1; fiq_idx <= fiq_sel; end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < 6'(NSRC)) rdata[CFG_W-1:0] = cfg[addr[IDX_W-1:0]];
    else
      case (addr)
        A_PEND: rdata = 32'(pend);
        A_MASK: rdata = 32'(mask_r);
        A_ISRC: rdata = irq_act ? 32'(NUM_BASE) + 32'(irq_idx) : '0;
        A_FSRC: rdata = fiq_act ? 32'(NUM_BASE) + 32'(fiq_idx) : '0;
        A_GATE: rdata = {31'b0, gate};
        default: rdata = '0;
      endcase
  end

  assign irq_n = ~irq_act;
  assign fiq_n = ~fiq_act;

  assert_ack_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |=> irq_n);
  assert_ack_fiq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fiq |=> fiq_n);
  assert_frozen_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_act && !ack_irq) |=> $stable(irq_idx));
  assert_gate_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && irq_n && fiq_n) |=> (irq_n && fiq_n));
  assert_seize_needs_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_act) |-> $past(irq_hit));
endmodule

// File: tb/tb_prio_irq_bank.sv
module tb_prio_irq_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_en2 = 1'b0;
  logic [5:0] addr = '0, addr2 = '0;
  logic [31:0] wdata = '0, wdata2 = '0, rdata, rdata2;
  logic [31:0] src = '0, src2 = '0;
  logic irq_n, fiq_n, irq_n2, fiq_n2;
  int n_tests = 0, n_fail = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  prio_irq_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_in(src), .irq_n(irq_n), .fiq_n(fiq_n));

  prio_irq_bank #(.FIQ_EN(0), .NUM_BASE(32)) dut2 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en2),
    .addr(addr2), .wdata(wdata2), .rdata(rdata2), .src_in(src2), .irq_n(irq_n2), .fiq_n(fiq_n2));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FIL %s: got %h want %h", req, act, exp);
    end
  endtask

  task automatic wr(bit b, logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    if (b) begin wr_en2 = 1'b1; addr2 = a; wdata2 = d; end
    else begin wr_en = 1'b1; addr = a; wdata = d; end
    @(posedge clk); #1;
    wr_en = 1'b0; wr_en2 = 1'b0;
  endtask

  task automatic rd(bit b, logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    if (b) begin addr2 = a; #1 d = rdata2; end
    else begin addr = a; #1 d = rdata; end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rd(0, 33, v); chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(0, 37, v); chk("R1 gate", v, 32'h1);
    rd(0, 5, v);  chk("R1 cfg", v, 32'h0);
    chk("R1 irq_n", {31'b0, irq_n}, 32'h1);
    chk("R1 fiq_n", {31'b0, fiq_n}, 32'h1);
  endtask

  task automatic t_cfg;
    wr(0, 3, 32'h7F);   rd(0, 3, v); chk("R2 cfg all", v, 32'h7F);
    wr(0, 3, 32'hFFFF); rd(0, 3, v); chk("R2 upper bits", v, 32'h7F);
    wr(0, 3, 32'h0);
  endtask

  task automatic t_level;
    wr(0, 37, 0);
    wr(0, 4, 32'h02);
    @(negedge clk) src[4] = 1'b1;
    cyc(3);
    chk("R4 masked", {31'b0, irq_n}, 32'h1);
    rd(0, 32, v); chk("R5 level pend", v, 32'h10);
    wr(0, 33, ~32'h10);
    cyc(1);
    chk("R4 unmasked", {31'b0, irq_n}, 32'h0);
    rd(0, 34, v); chk("R8 src", v, 32'd4);
    wr(0, 36, 32'h1);
    chk("R9 drop", {31'b0, irq_n}, 32'h1);
    cyc(1);
    chk("R9 reassert", {31'b0, irq_n}, 32'h0);
    @(negedge clk) src[4] = 1'b0;
    rd(0, 32, v); chk("R5 level follows", v, 32'h0);
    wr(0, 36, 32'h1);
    cyc(2);
    chk("R9 idle", {31'b0, irq_n}, 32'h1);
    rd(0, 34, v); chk("R8 idle src", v, 32'h0);
  endtask

  task automatic t_edge;
    wr(0, 7, 32'h00);
    wr(0, 33, ~32'h80);
    @(negedge clk) src[7] = 1'b1;
    @(negedge clk) src[7] = 1'b0;
    cyc(2);
    chk("R5 edge req", {31'b0, irq_n}, 32'h0);
    rd(0, 32, v); chk("R5 sticky", v, 32'h80);
    rd(0, 34, v); chk("R8 edge src", v, 32'd7);
    wr(0, 36, 32'h1);
    cyc(2);
    chk("R10 cleared", {31'b0, irq_n}, 32'h1);
    rd(0, 32, v); chk("R10 pend", v, 32'h0);
    wr(0, 33, 32'hFFFF_FFFF);
    @(negedge clk) src[7] = 1'b1;
    @(negedge clk) src[7] = 1'b0;
    cyc(1);
    rd(0, 32, v); chk("R5 masked sticky", v, 32'h80);
    wr(0, 32, 32'h0);
    rd(0, 32, v); chk("R5 write clear", v, 32'h0);
  endtask

  task automatic t_prio;
    wr(0, 10, 32'h16);
    wr(0, 12, 32'h0E);
    wr(0, 20, 32'h0E);
    wr(0, 33, ~32'h0010_1400);
    @(negedge clk) src[10] = 1'b1;
    cyc(2);
    rd(0, 34, v); chk("R8 first", v, 32'd10);
    @(negedge clk) begin src[12] = 1'b1; src[20] = 1'b1; end
    cyc(2);
    rd(0, 34, v); chk("R8 frozen", v, 32'd10);
    wr(0, 36, 32'h1); cyc(1);
    rd(0, 34, v); chk("R7 tie low index", v, 32'd12);
    @(negedge clk) src[12] = 1'b0;
    wr(0, 36, 32'h1); cyc(1);
    rd(0, 34, v); chk("R7 next tie", v, 32'd20);
    @(negedge clk) src[20] = 1'b0;
    wr(0, 36, 32'h1); cyc(1);
    rd(0, 34, v); chk("R7 worse prio", v, 32'd10);
    @(negedge clk) src[10] = 1'b0;
    wr(0, 36, 32'h1); cyc(2);
    chk("R7 idle", {31'b0, irq_n}, 32'h1);
  endtask

  task automatic t_fiq;
    wr(0, 1, 32'h03);
    wr(0, 33, ~32'h2);
    @(negedge clk) src[1] = 1'b1;
    cyc(2);
    chk("R3 fiq low", {31'b0, fiq_n}, 32'h0);
    chk("R3 irq high", {31'b0, irq_n}, 32'h1);
    rd(0, 35, v); chk("R8 fiq src", v, 32'd1);
    wr(0, 36, 32'h1); cyc(1);
    chk("R9 irq ack no fiq effect", {31'b0, fiq_n}, 32'h0);
    @(negedge clk) src[1] = 1'b0;
    wr(0, 36, 32'h2);
    chk("R9 fiq drop", {31'b0, fiq_n}, 32'h1);
    cyc(2);
    rd(0, 35, v); chk("R8 fiq idle", v, 32'h0);
  endtask

  task automatic t_gate;
    wr(0, 37, 32'h1);
    wr(0, 33, ~32'h10);
    @(negedge clk) src[4] = 1'b1;
    cyc(3);
    chk("R6 gated", {31'b0, irq_n}, 32'h1);
    wr(0, 37, 32'h0); cyc(1);
    chk("R6 open", {31'b0, irq_n}, 32'h0);
    @(negedge clk) src[4] = 1'b0;
    wr(0, 36, 32'h1); cyc(2);
  endtask

  task automatic t_bank2;
    wr(1, 1, 32'h03);
    rd(1, 1, v); chk("R3 no fiq bit", v, 32'h02);
    wr(1, 37, 32'h0);
    wr(1, 33, ~32'h2);
    @(negedge clk) src2[1] = 1'b1;
    cyc(2);
    chk("R3 second irq", {31'b0, irq_n2}, 32'h0);
    chk("R3 second fiq", {31'b0, fiq_n2}, 32'h1);
    rd(1, 34, v); chk("R11 offset", v, 32'd33);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    @(negedge clk) rst_n = 1'b1;
    t_reset;
    t_cfg;
    t_level;
    t_edge;
    t_prio;
    t_fiq;
    t_gate;
    t_bank2;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule